// File: doc/BRIEF.md
# Codec-to-CPU Serial Sample Bridge

This block parks one 16-bit audio sample between a serial audio codec and a processor's synchronous serial port. Each side makes its own shift clock, and both share one 16-bit shift register in turns. While the codec's frame sync is high, the codec bit clock and codec data drive the register. Between frames, the processor's shift clock and data drive it. Every access is full duplex: the sample already held leaves on the shared serial output, most significant bit first, while the new sample enters behind it.

All serial inputs are oversampled on a fast system clock. The system clock must run at least eight times faster than the faster serial clock. Each serial input passes through a synchronizer of the same depth, so clocks and data stay aligned. On a rising edge of the selected serial clock, the block launches the next output bit. On a falling edge, which is the middle of the bit cell, it samples the input bit. The codec's clock runs all the time, so a frame counter closes the codec clock path in the middle of bit 16. When fsync falls, a rising edge can come at the same time, and this keeps that edge from shifting the register. After a codec frame completes, a level interrupt asks the processor to collect the sample.

The block moves serial bits only. No parallel word crosses its boundary, so it has no valid/ready stream interface and applies no back-pressure. The processor must finish its 16 shifts before the next codec frame starts.

Top module: `codec_cpu_bridge`

## Requirements
- R1: After reset, the shared register holds all zeros, `ser_dout` is 0 and `frame_irq` is 0.
- R2: While `codec_fsync` is high, each falling `codec_bclk` edge shifts `codec_din` into the register LSB-ward, and each rising edge drives the next held bit onto `ser_dout`, MSB first. The codec therefore receives the previous content and leaves its own 16-bit word.
- R3: While `codec_fsync` is low, `codec_bclk` and `codec_din` have no effect on `ser_dout` or on the register content.
- R4: The codec clock path closes in the middle of bit 16. Codec clock edges after the 16th falling edge do not shift the register, even if fsync stays high longer, and neither does the rising edge that comes together with the fall of fsync.
- R5: `frame_irq` rises within a few system cycles of the 16th falling `codec_bclk` edge of a frame.
- R6: `frame_irq` clears on the first rising `cpu_sck` edge after it was set.
- R7: A one-cycle pulse on `irq_clr` clears `frame_irq` without any serial activity.
- R8: While `codec_fsync` is low, each rising `cpu_sck` edge drives the next held bit onto `ser_dout`, MSB first, and each falling edge shifts `cpu_din` into the register. A pause between the two 8-bit groups does not disturb the transfer.
- R9: During a codec frame the register input takes `codec_din` only. A level held on `cpu_din` after a processor transfer does not reach the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the faster serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| codec_bclk | input | 1 | Continuous codec bit clock |
| codec_fsync | input | 1 | Codec frame sync, high for bits 1 to 16 |
| codec_din | input | 1 | Codec serial data into the register |
| cpu_sck | input | 1 | Processor shift clock, idle low |
| cpu_din | input | 1 | Processor serial data into the register |
| irq_clr | input | 1 | Single-cycle clear of the frame interrupt |
| ser_dout | output | 1 | Shared serial output to codec and processor |
| frame_irq | output | 1 | Level interrupt: a codec frame has completed |

## Verification
The table passes alternating codec and processor words through the register. The patterns are all zeros, all ones, alternating bits, single set bits at either end and mixed values. A swapped bit order, a lost first or last bit, or a stuck output line makes the words read back on each side differ. A frame held four bits past its length with ones on the codec line tells a correctly closed clock gate from a late one. A codec frame of zeros sent while the processor line is held high shows whether the data multiplexer is complete. Idle codec clocking between frames, and interrupt clearing by a pulse as well as by the first processor edge, cover the remaining control paths.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  parameter int unsigned SB_SAMPLE_W = 16;
  parameter int unsigned SB_SYNC_N   = 2;
  // positions inside the synchronized input vector
  localparam int unsigned IX_BCLK = 0;
  localparam int unsigned IX_FS   = 1;
  localparam int unsigned IX_SCK  = 2;
  localparam int unsigned IX_CDIN = 3;
  localparam int unsigned IX_PDIN = 4;
  localparam int unsigned IX_NUM  = 5;
  localparam int unsigned IX_EDGE = 3; // clocks and fsync get edge detection
endpackage

// File: rtl/sb_sync.sv
`timescale 1ns/1ps
module sb_sync #(
  parameter int unsigned W = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sb_edge.sv
`timescale 1ns/1ps
module sb_edge #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sb_frame_ctl.sv
`timescale 1ns/1ps
module sb_frame_ctl #(
  parameter int unsigned SAMPLE_W = 16,
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_lvl,
  input  logic fs_rise,
  input  logic fs_fall,
  input  logic bclk_fall,
  input  logic sck_rise,
  input  logic irq_clr,
  output logic codec_en,
  output logic irq
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             gate_q;

  // mid-bit counter: advances on falling codec clock, held at zero between frames
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          bit_cnt <= '0;
    else if (!fs_lvl)                    bit_cnt <= '0;
    else if (bclk_fall && bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
  end

  // codec clock enable: opened by fsync rising, closed once the count is full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gate_q <= 1'b0;
    else if (fs_rise)          gate_q <= 1'b1;
    else if (bit_cnt == FULL)  gate_q <= 1'b0;
  end

  // the first rising edge of a frame coincides with fsync rising
  assign codec_en = gate_q | fs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    irq <= 1'b0;
    else if (fs_lvl && bclk_fall && bit_cnt == LAST) irq <= 1'b1;
    else if (sck_rise || irq_clr)                  irq <= 1'b0;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  p_gate_shut_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fs_fall |-> !gate_q);
  p_irq_after_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> bit_cnt == FULL);
endmodule

// File: rtl/sb_shift.sv
`timescale 1ns/1ps
module sb_shift #(
  parameter int unsigned W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,   // rising edge of the selected serial clock
  input  logic sample,   // falling edge of the selected serial clock
  input  logic din,
  output logic dout
);
  logic [W-1:0] sr;
  logic         out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (sample) sr <= {sr[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (launch) out_q <= sr[W-1];
  end

  assign dout = out_q;

  p_no_double_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sample));
endmodule

// File: rtl/codec_cpu_bridge.sv
`timescale 1ns/1ps
module codec_cpu_bridge
  import sb_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SB_SAMPLE_W,
  parameter int unsigned SYNC_N   = SB_SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic codec_bclk,
  input  logic codec_fsync,
  input  logic codec_din,
  input  logic cpu_sck,
  input  logic cpu_din,
  input  logic irq_clr,
  output logic ser_dout,
  output logic frame_irq
);
  logic [IX_NUM-1:0]  raw, syn;
  logic [IX_EDGE-1:0] rise, fall;
  logic               codec_en, launch, sample, din_sel;

  assign raw[IX_BCLK] = codec_bclk;
  assign raw[IX_FS]   = codec_fsync;
  assign raw[IX_SCK]  = cpu_sck;
  assign raw[IX_CDIN] = codec_din;
  assign raw[IX_PDIN] = cpu_din;

  sb_sync #(.W(IX_NUM), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw), .q_sync(syn));

  sb_edge #(.W(IX_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn[IX_EDGE-1:0]), .rise(rise), .fall(fall));

  sb_frame_ctl #(.SAMPLE_W(SAMPLE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .fs_lvl(syn[IX_FS]), .fs_rise(rise[IX_FS]), .fs_fall(fall[IX_FS]),
    .bclk_fall(fall[IX_BCLK]), .sck_rise(rise[IX_SCK]), .irq_clr(irq_clr),
    .codec_en(codec_en), .irq(frame_irq));

  // clock merge: gated codec clock or processor clock (idle low between transfers)
  assign launch  = (codec_en & rise[IX_BCLK]) | rise[IX_SCK];
  assign sample  = (codec_en & fall[IX_BCLK]) | fall[IX_SCK];
  // full data multiplexer, steered by synchronized fsync
  assign din_sel = syn[IX_FS] ? syn[IX_CDIN] : syn[IX_PDIN];

  sb_shift #(.W(SAMPLE_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .sample(sample),
    .din(din_sel), .dout(ser_dout));

  p_quiet_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!syn[IX_FS] && !rise[IX_SCK]) |=> $stable(ser_dout));
  p_cpu_idle_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    syn[IX_FS] |-> !syn[IX_SCK]);
endmodule

// File: tb/sim_codec_cpu_bridge.sv
`timescale 1ns/1ps
module sim_codec_cpu_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic codec_bclk = 0, codec_fsync = 0, codec_din = 0;
  logic cpu_sck = 0, cpu_din = 0, irq_clr = 0;
  logic ser_dout, frame_irq;
  int n_chk = 0, n_fail = 0;
  localparam int HB = 8; // serial half bit in system cycles

  always #2 clk = ~clk; // 250 MHz

  codec_cpu_bridge u0 (.clk(clk), .rst_n(rst_n), .codec_bclk(codec_bclk),
    .codec_fsync(codec_fsync), .codec_din(codec_din), .cpu_sck(cpu_sck),
    .cpu_din(cpu_din), .irq_clr(irq_clr), .ser_dout(ser_dout), .frame_irq(frame_irq));

  typedef struct packed { logic [15:0] cw; logic [15:0] pw; } vec_t;
  localparam vec_t VECS [6] = '{
    '{16'h0000, 16'hFFFF}, '{16'hFFFF, 16'h0000}, '{16'hA5A5, 16'h5A5A},
    '{16'h8001, 16'h7FFE}, '{16'h1234, 16'hFEDC}, '{16'h0F0F, 16'h8000}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); codec_bclk = 1; codec_din = i[0];
      repeat (HB) @(negedge clk); codec_bclk = 0;
      repeat (HB) @(negedge clk);
    end
  endtask

  task automatic codec_frame(input logic [15:0] tx, input int nbits, output logic [15:0] seen);
    seen = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); codec_bclk = 1; codec_fsync = 1;
      codec_din = (i < 16) ? tx[15-i] : 1'b1;
      repeat (HB) @(negedge clk);
      if (i < 16) seen = {seen[14:0], ser_dout};
      codec_bclk = 0;
      repeat (HB) @(negedge clk);
    end
    codec_bclk = 1; codec_fsync = 0; codec_din = 1;
    repeat (HB) @(negedge clk); codec_bclk = 0;
    repeat (HB) @(negedge clk);
  endtask

  task automatic cpu_xfer(input logic [15:0] tx, output logic [15:0] rx);
    rx = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); cpu_sck = 1; cpu_din = tx[15-i];
      repeat (HB) @(negedge clk);
      rx = {rx[14:0], ser_dout};
      cpu_sck = 0;
      repeat (HB) @(negedge clk);
      if (i == 7) repeat (20) @(negedge clk); // gap between byte groups
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] seen, rx, prev, hold;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 ser_dout after reset", {15'b0, ser_dout}, 16'h0);
    chk("R1 frame_irq after reset", {15'b0, frame_irq}, 16'h0);
    prev = '0; // R1: register resets to zero
    for (int v = 0; v < 6; v++) begin
      idle_bits(3);
      codec_frame(VECS[v].cw, 16, seen);
      chk("R2 codec sees previous word", seen, prev);
      chk("R5 irq after frame", {15'b0, frame_irq}, 16'h1);
      cpu_xfer(VECS[v].pw, rx);
      chk("R8 cpu reads codec word", rx, VECS[v].cw);
      chk("R6 irq cleared by cpu clock", {15'b0, frame_irq}, 16'h0);
      prev = VECS[v].pw;
    end
    // R3: idle codec clocking leaves output and content alone
    hold = {15'b0, ser_dout};
    idle_bits(10);
    chk("R3 ser_dout stable between frames", {15'b0, ser_dout}, hold);
    codec_frame(16'hC3C3, 16, seen);
    chk("R3 content kept through idle clocks", seen, prev);
    // R7: clear pulse
    chk("R5 irq set before clear", {15'b0, frame_irq}, 16'h1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    repeat (2) @(negedge clk);
    chk("R7 irq cleared by pulse", {15'b0, frame_irq}, 16'h0);
    cpu_xfer(16'h0001, rx); // ends with cpu_din held high
    chk("R8 cpu read after pulse clear", rx, 16'hC3C3);
    // R9: codec zeros while cpu line held high
    codec_frame(16'h0000, 16, seen);
    chk("R9 codec saw cpu word", seen, 16'h0001);
    cpu_xfer(16'h6E6E, rx);
    chk("R9 held cpu level not captured", rx, 16'h0000);
    // R4: fsync held 4 bits too long, extra bits are ones
    codec_frame(16'h2468, 20, seen);
    chk("R4 long frame output", seen, 16'h6E6E);
    cpu_xfer(16'h0000, rx);
    chk("R4 extra bits ignored", rx, 16'h2468);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule